// File: doc/BRIEF.md
# Line Transmit Pattern Generator with Error Injection

This block chooses the bit stream handed to a T1/E1 line driver and converts it into bipolar AMI rail pulses. One bit leaves per cycle in which the transmit clock enable `tx_ce` is high. Between those cycles the rails hold their last value. The bit can come from several sources: serial input data, unframed all ones, a 1,0,1,0 alternation, a maximal-length pseudo-random sequence, or a short loop code repeated without end. A line-mode input sets the pseudo-random polynomial: 15 stages for E1, 20 stages for T1.

The source is held in a state register, `src_q`. Each clock it takes the highest-priority request, in this order: SRC_ONES, SRC_ALT, SRC_PRBS, SRC_LOOP, SRC_DATA. SRC_ONES is chosen while the transmit-enable control is low, or while auto all-ones is enabled and carrier loss or received all ones is reported. Any state can move to any other state in a single clock. Because of this register, a change on a control input takes effect after one clock.

Both error injections are one-shot and fire on the rising edge of their control. A rising edge on the bit-error control inverts the next bit sent. The encoder moves from ENC_DISARMED to ENC_ARMED on a rising edge of the violation control. While armed, it sends the next one that completes a run of three consecutive ones with the same polarity as the previous one, and then returns to ENC_DISARMED.

Top module: `line_tx_patgen`

## Requirements
- R1: Out of reset both rails are low, and the first one sent after reset goes on the positive rail. While `ctl_tx_en` is 0, every bit sent is a one.
- R2: While `ctl_auto_ones` is 1 and either `rx_carrier_loss` or `rx_all_ones` is 1, every bit sent is a one. While `ctl_auto_ones` is 0, those two inputs have no effect.
- R3: The source priority runs from highest to lowest as: all ones, alternation, pseudo-random, loop code, serial data.
- R4: On entry, the alternation source sends 1 and then 0 on each following enabled cycle, continuing 1,0,1,0.
- R5: With `e1_mode`=1, the pseudo-random bits obey b[n] = b[n-15] xor b[n-14] and repeat with period 32767, with 16384 ones per period.
- R6: With `e1_mode`=0, the pseudo-random bits obey b[n] = b[n-20] xor b[n-17] and are never all zero.
- R7: The loop code sends bits `loop_code[7]`, `loop_code[6]` and so on, cyclically. The length is 5, 6 or 7 for `loop_len` values 0, 1 and 2, and 7 for value 3. Each entry to the loop state restarts at `loop_code[7]`.
- R8: Each 0-to-1 change of `ctl_ins_err` inverts exactly one bit: the next bit sent after the clock that detects the edge. Holding the control high has no further effect.
- R9: Each 0-to-1 change of `ctl_ins_bpv` arms exactly one violation. The violation is the first one sent that has at least two ones directly before it, and it goes on the same rail as the previous one. Holding the control high arms nothing more.
- R10: A one goes on the rail opposite to the previous one, and the alternation resumes after a violation. A zero drives both rails low. The two rails are never high together.
- R11: While `tx_ce` is 0, both rails hold their values and no source or counter advances. Serial data is sampled at the enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_ce | input | 1 | Transmit bit enable |
| e1_mode | input | 1 | 1 selects E1 (15-stage sequence), 0 selects T1 (20-stage sequence) |
| tx_data | input | 1 | Serial transmit data |
| ctl_tx_en | input | 1 | 0 forces all ones, 1 lets the other sources through |
| ctl_auto_ones | input | 1 | Enables all ones on receive alarms |
| rx_carrier_loss | input | 1 | Receive carrier loss alarm |
| rx_all_ones | input | 1 | Receive all-ones alarm |
| ctl_alt | input | 1 | Select the 1,0 alternation |
| ctl_prbs | input | 1 | Select the pseudo-random sequence |
| ctl_loop | input | 1 | Select the loop code |
| loop_len | input | 2 | Loop code length select |
| loop_code | input | 8 | Loop code bits, sent MSB first |
| ctl_ins_err | input | 1 | Rising edge inserts one bit error |
| ctl_ins_bpv | input | 1 | Rising edge arms one bipolar violation |
| out_pos | output | 1 | Positive rail pulse |
| out_neg | output | 1 | Negative rail pulse |

## Verification
The bench runs through all sixteen combinations of the four source controls and classifies the 16 bits that follow. A wrong priority order therefore shows up as the wrong pattern class. It checks the recurrence and the ones count over a full E1 period, which catches a wrong tap position or a sequence that loops early. It also checks the T1 recurrence. Each loop length is checked, including the restart on re-entry; a design that kept the index across entries would send a shifted code. Error injection is checked with the control held high, re-raised, and raised while bits are flowing; a level-sensitive design would keep corrupting bits. The violation is armed both mid-run and after a run of ones is already present, so a design that counts ones only after arming, or keeps the wrong polarity afterwards, produces a mismatched rail.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    // Bit source, listed from highest to lowest priority
    typedef enum logic [2:0] {
        SRC_ONES = 3'd0,
        SRC_ALT  = 3'd1,
        SRC_PRBS = 3'd2,
        SRC_LOOP = 3'd3,
        SRC_DATA = 3'd4
    } src_e;

    // Violation arming state of the line encoder
    typedef enum logic {
        ENC_DISARMED = 1'b0,
        ENC_ARMED    = 1'b1
    } enc_e;

endpackage

// File: rtl/ltx_src_fsm.sv
module ltx_src_fsm
    import ltx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_ce,
    input  logic ctl_tx_en,
    input  logic ctl_auto_ones,
    input  logic rx_carrier_loss,
    input  logic rx_all_ones,
    input  logic ctl_alt,
    input  logic ctl_prbs,
    input  logic ctl_loop,
    input  logic data_in,
    input  logic prbs_bit,
    input  logic loop_bit,
    output src_e src_q,
    output logic prbs_adv,
    output logic loop_run,
    output logic bit_out
);

    src_e src_d;
    logic alt_ph;
    logic auto_hit;

    assign auto_hit = ctl_auto_ones && (rx_carrier_loss || rx_all_ones);

    // Next source by fixed priority
    always_comb begin
        if (!ctl_tx_en || auto_hit) begin
            src_d = SRC_ONES;
        end else if (ctl_alt) begin
            src_d = SRC_ALT;
        end else if (ctl_prbs) begin
            src_d = SRC_PRBS;
        end else if (ctl_loop) begin
            src_d = SRC_LOOP;
        end else begin
            src_d = SRC_DATA;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_ONES;
        end else begin
            src_q <= src_d;
        end
    end

    // Alternation phase: restarts at one whenever the state is left
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alt_ph <= 1'b1;
        end else if (src_q != SRC_ALT) begin
            alt_ph <= 1'b1;
        end else if (tx_ce) begin
            alt_ph <= ~alt_ph;
        end
    end

    // Outputs by state
    always_comb begin
        prbs_adv = 1'b0;
        loop_run = 1'b0;
        bit_out  = 1'b1;
        unique case (src_q)
            SRC_ONES: bit_out = 1'b1;
            SRC_ALT:  bit_out = alt_ph;
            SRC_PRBS: begin
                bit_out  = prbs_bit;
                prbs_adv = tx_ce;
            end
            SRC_LOOP: begin
                bit_out  = loop_bit;
                loop_run = 1'b1;
            end
            SRC_DATA: bit_out = data_in;
            default:  bit_out = 1'b1;
        endcase
    end

    // R1
    ones_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_tx_en |=> (src_q == SRC_ONES));

    // R2
    auto_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_tx_en && ctl_auto_ones && (rx_carrier_loss || rx_all_ones)) |=> (src_q == SRC_ONES));

    // R3
    alt_over_prbs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_tx_en && !ctl_auto_ones && ctl_alt) |=> (src_q == SRC_ALT));

    // R4
    alt_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_ALT && tx_ce) |=> (src_q != SRC_ALT) || (alt_ph != $past(alt_ph)));

endmodule

// File: rtl/ltx_prbs.sv
module ltx_prbs #(
    parameter int E1_LEN = 15,
    parameter int E1_TAP = 14,
    parameter int T1_LEN = 20,
    parameter int T1_TAP = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e1_mode,
    input  logic adv,
    output logic bit_o
);

    localparam int SR_W = (T1_LEN > E1_LEN) ? T1_LEN : E1_LEN;

    logic [SR_W-1:0] sr;
    logic            fb;
    logic            win_zero;

    always_comb begin
        if (e1_mode) begin
            bit_o    = sr[E1_LEN-1];
            fb       = sr[E1_LEN-1] ^ sr[E1_TAP-1];
            win_zero = (sr[E1_LEN-1:0] == '0);
        end else begin
            bit_o    = sr[T1_LEN-1];
            fb       = sr[T1_LEN-1] ^ sr[T1_TAP-1];
            win_zero = (sr[T1_LEN-1:0] == '0);
        end
    end

    // A zero window (possible after a mode change) is reseeded to all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '1;
        end else if (win_zero) begin
            sr <= '1;
        end else if (adv) begin
            sr <= {sr[SR_W-2:0], fb};
        end
    end

    // R5
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (sr != '0));

    // R11
    prbs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !win_zero) |=> $stable(sr));

endmodule

// File: rtl/ltx_loopcode.sv
module ltx_loopcode #(
    parameter int CODE_W   = 8,
    parameter int LEN_SEL_W = 2,
    parameter int LOOP_MIN = 5,
    parameter int LOOP_MAX = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 adv,
    input  logic [LEN_SEL_W-1:0] len_sel,
    input  logic [CODE_W-1:0]    code,
    output logic                 bit_o
);

    localparam int IDX_W    = $clog2(CODE_W);
    localparam int SPAN     = LOOP_MAX - LOOP_MIN;
    localparam logic [IDX_W-1:0] MIN_LAST = IDX_W'(LOOP_MIN - 1);
    localparam logic [IDX_W-1:0] MAX_LAST = IDX_W'(LOOP_MAX - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        if (int'(len_sel) >= SPAN) begin
            last_idx = MAX_LAST;
        end else begin
            last_idx = MIN_LAST + IDX_W'(len_sel);
        end
    end

    assign bit_o = code[CODE_W-1-int'(idx)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!run) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx >= last_idx) ? '0 : idx + 1'b1;
        end
    end

    // R7
    loop_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= MAX_LAST);

    // R7
    loop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (idx == '0));

endmodule

// File: rtl/ltx_line_enc.sv
module ltx_line_enc
    import ltx_pkg::*;
#(
    parameter int BPV_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_ce,
    input  logic bit_in,
    input  logic ctl_ins_err,
    input  logic ctl_ins_bpv,
    output logic out_pos,
    output logic out_neg
);

    localparam int RUN_W = $clog2(BPV_RUN);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(BPV_RUN - 1);

    enc_e             enc_st;
    enc_e             enc_nx;
    logic             err_q;
    logic             bpv_q;
    logic             err_rise;
    logic             bpv_rise;
    logic             err_pend;
    logic             bit_tx;
    logic             viol;
    logic             pol;
    logic [RUN_W-1:0] run_q;

    assign err_rise = ctl_ins_err && !err_q;
    assign bpv_rise = ctl_ins_bpv && !bpv_q;
    assign bit_tx   = bit_in ^ err_pend;

    // Registered copies of the controls for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            bpv_q <= 1'b0;
        end else begin
            err_q <= ctl_ins_err;
            bpv_q <= ctl_ins_bpv;
        end
    end

    // Pending bit error, used up by the next bit sent
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pend <= 1'b0;
        end else if (err_rise) begin
            err_pend <= 1'b1;
        end else if (tx_ce) begin
            err_pend <= 1'b0;
        end
    end

    // Next arming state
    always_comb begin
        enc_nx = enc_st;
        viol   = 1'b0;
        unique case (enc_st)
            ENC_DISARMED: begin
                if (bpv_rise) begin
                    enc_nx = ENC_ARMED;
                end
            end
            ENC_ARMED: begin
                if (tx_ce && bit_tx && (run_q >= RUN_FULL)) begin
                    viol   = 1'b1;
                    enc_nx = bpv_rise ? ENC_ARMED : ENC_DISARMED;
                end
            end
            default: enc_nx = ENC_DISARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_st <= ENC_DISARMED;
        end else begin
            enc_st <= enc_nx;
        end
    end

    // Run length of ones and last pulse polarity (1 = positive)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            pol   <= 1'b0;
        end else if (tx_ce) begin
            if (bit_tx) begin
                if (run_q < RUN_FULL) begin
                    run_q <= run_q + 1'b1;
                end
                if (!viol) begin
                    pol <= ~pol;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    // Rail outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pos <= 1'b0;
            out_neg <= 1'b0;
        end else if (tx_ce) begin
            out_pos <= bit_tx && (viol ? pol : !pol);
            out_neg <= bit_tx && (viol ? !pol : pol);
        end
    end

    // R10
    no_dual_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_pos && out_neg));

    // R10
    ami_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ce && bit_tx && enc_st == ENC_DISARMED) |=> (out_pos == !$past(pol)) && (out_neg == $past(pol)));

    // R11
    rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ce |=> $stable(out_pos) && $stable(out_neg));

    // R8
    err_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ce && err_pend && !err_rise) |=> !err_pend);

    // R9
    bpv_wait_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_st == ENC_ARMED && tx_ce && run_q < RUN_FULL) |=> (enc_st == ENC_ARMED));

endmodule

// File: rtl/line_tx_patgen.sv
module line_tx_patgen
    import ltx_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int LEN_SEL_W = 2,
    parameter int LOOP_MIN  = 5,
    parameter int LOOP_MAX  = 7,
    parameter int BPV_RUN   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_ce,
    input  logic                 e1_mode,
    input  logic                 tx_data,
    input  logic                 ctl_tx_en,
    input  logic                 ctl_auto_ones,
    input  logic                 rx_carrier_loss,
    input  logic                 rx_all_ones,
    input  logic                 ctl_alt,
    input  logic                 ctl_prbs,
    input  logic                 ctl_loop,
    input  logic [LEN_SEL_W-1:0] loop_len,
    input  logic [CODE_W-1:0]    loop_code,
    input  logic                 ctl_ins_err,
    input  logic                 ctl_ins_bpv,
    output logic                 out_pos,
    output logic                 out_neg
);

    src_e src_q;
    logic prbs_adv;
    logic loop_run;
    logic loop_adv;
    logic prbs_bit;
    logic loop_bit;
    logic sel_bit;

    assign loop_adv = loop_run && tx_ce;

    ltx_src_fsm u_src (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_ce           (tx_ce),
        .ctl_tx_en       (ctl_tx_en),
        .ctl_auto_ones   (ctl_auto_ones),
        .rx_carrier_loss (rx_carrier_loss),
        .rx_all_ones     (rx_all_ones),
        .ctl_alt         (ctl_alt),
        .ctl_prbs        (ctl_prbs),
        .ctl_loop        (ctl_loop),
        .data_in         (tx_data),
        .prbs_bit        (prbs_bit),
        .loop_bit        (loop_bit),
        .src_q           (src_q),
        .prbs_adv        (prbs_adv),
        .loop_run        (loop_run),
        .bit_out         (sel_bit)
    );

    ltx_prbs u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .e1_mode (e1_mode),
        .adv     (prbs_adv),
        .bit_o   (prbs_bit)
    );

    ltx_loopcode #(
        .CODE_W    (CODE_W),
        .LEN_SEL_W (LEN_SEL_W),
        .LOOP_MIN  (LOOP_MIN),
        .LOOP_MAX  (LOOP_MAX)
    ) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (loop_run),
        .adv     (loop_adv),
        .len_sel (loop_len),
        .code    (loop_code),
        .bit_o   (loop_bit)
    );

    ltx_line_enc #(
        .BPV_RUN (BPV_RUN)
    ) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_ce       (tx_ce),
        .bit_in      (sel_bit),
        .ctl_ins_err (ctl_ins_err),
        .ctl_ins_bpv (ctl_ins_bpv),
        .out_pos     (out_pos),
        .out_neg     (out_neg)
    );

    // R3
    prbs_runs_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prbs_adv |-> (src_q == SRC_PRBS) && tx_ce);

endmodule

// File: tb/line_tx_patgen_tb_top.sv
module line_tx_patgen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_ce = 1'b0;
    logic       e1_mode = 1'b1;
    logic       tx_data = 1'b0;
    logic       ctl_tx_en = 1'b0;
    logic       ctl_auto_ones = 1'b0;
    logic       rx_carrier_loss = 1'b0;
    logic       rx_all_ones = 1'b0;
    logic       ctl_alt = 1'b0;
    logic       ctl_prbs = 1'b0;
    logic       ctl_loop = 1'b0;
    logic [1:0] loop_len = 2'd0;
    logic [7:0] loop_code = 8'h00;
    logic       ctl_ins_err = 1'b0;
    logic       ctl_ins_bpv = 1'b0;
    logic       out_pos;
    logic       out_neg;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  pol_m = 1'b0;   // last one polarity in the bench model, 1 = positive

    always #10 clk = ~clk;

    line_tx_patgen dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_ce           (tx_ce),
        .e1_mode         (e1_mode),
        .tx_data         (tx_data),
        .ctl_tx_en       (ctl_tx_en),
        .ctl_auto_ones   (ctl_auto_ones),
        .rx_carrier_loss (rx_carrier_loss),
        .rx_all_ones     (rx_all_ones),
        .ctl_alt         (ctl_alt),
        .ctl_prbs        (ctl_prbs),
        .ctl_loop        (ctl_loop),
        .loop_len        (loop_len),
        .loop_code       (loop_code),
        .ctl_ins_err     (ctl_ins_err),
        .ctl_ins_bpv     (ctl_ins_bpv),
        .out_pos         (out_pos),
        .out_neg         (out_neg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare the rails with the AMI model for one sent bit
    task automatic rails(input bit exp_b, input bit viol, input string tag);
        bit ep;
        bit en;
        if (exp_b) begin
            if (!viol) pol_m = ~pol_m;
            ep = pol_m;
            en = ~pol_m;
        end else begin
            ep = 1'b0;
            en = 1'b0;
        end
        chk({out_pos, out_neg} == {ep, en}, tag, int'({out_pos, out_neg}), int'({ep, en}));
    endtask

    // One enabled bit with given data; the result is read at the next falling edge
    task automatic send(input bit d, input bit exp_b, input bit viol, input string tag);
        tx_ce = 1'b1;
        tx_data = d;
        @(negedge clk);
        rails(exp_b, viol, tag);
    endtask

    // One enabled bit, returning the observed bit after an AMI check
    task automatic recv(input bit d, output bit b, input string tag);
        tx_ce = 1'b1;
        tx_data = d;
        @(negedge clk);
        b = out_pos | out_neg;
        rails(b, 1'b0, tag);
    endtask

    // Two idle cycles so a control change reaches the source state
    task automatic settle();
        tx_ce = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_src(input bit en, input bit alt, input bit prbs, input bit lp);
        ctl_tx_en = en;
        ctl_alt = alt;
        ctl_prbs = prbs;
        ctl_loop = lp;
        settle();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit b;
        bit hp, hn;
        bit [15:0] v;
        bit [19:0] hist;
        bit [14:0] first;
        int ones;
        int exp_cls;
        int got_cls;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of the rails
        chk(!out_pos && !out_neg, "R1 reset rails", int'({out_pos, out_neg}), 0);

        // R1, R10: disabled transmit sends ones with alternating rails
        for (int i = 0; i < 8; i++) send(1'b0, 1'b1, 1'b0, "R1 ones while disabled");

        // R11: idle cycles hold the rails
        hp = out_pos;
        hn = out_neg;
        tx_ce = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_pos == hp && out_neg == hn, "R11 hold on idle", int'({out_pos, out_neg}), int'({hp, hn}));

        // R2: auto all ones on alarms
        set_src(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) send(1'b0, 1'b0, 1'b0, "R11 data zeros");
        ctl_auto_ones = 1'b1;
        rx_carrier_loss = 1'b1;
        settle();
        for (int i = 0; i < 3; i++) send(1'b0, 1'b1, 1'b0, "R2 ones on carrier loss");
        rx_carrier_loss = 1'b0;
        rx_all_ones = 1'b1;
        settle();
        for (int i = 0; i < 3; i++) send(1'b0, 1'b1, 1'b0, "R2 ones on received all ones");
        ctl_auto_ones = 1'b0;
        rx_carrier_loss = 1'b1;
        settle();
        for (int i = 0; i < 3; i++) send(1'b0, 1'b0, 1'b0, "R2 alarms ignored when auto off");
        rx_carrier_loss = 1'b0;
        rx_all_ones = 1'b0;

        // R3, R4: sweep all source control combinations
        e1_mode = 1'b1;
        loop_code = 8'h00;
        for (int c = 0; c < 16; c++) begin
            set_src(c[3], c[2], c[1], c[0]);
            for (int i = 0; i < 16; i++) begin
                recv((i % 4) >= 2, b, "R10 sweep rails");
                v[i] = b;
            end
            if (!c[3]) exp_cls = 0;
            else if (c[2]) exp_cls = 1;
            else if (c[1]) exp_cls = 2;
            else if (c[0]) exp_cls = 3;
            else exp_cls = 4;
            if (v == 16'hFFFF) got_cls = 0;
            else if (v == 16'h5555) got_cls = 1;
            else if (v == 16'h0000) got_cls = 3;
            else if (v == 16'hCCCC) got_cls = 4;
            else got_cls = 2;
            chk(got_cls == exp_cls, "R3 source priority", got_cls, exp_cls);
        end

        // R4: alternation restarts at one
        set_src(1'b1, 1'b0, 1'b0, 1'b0);
        set_src(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) send(1'b0, (i % 2) == 0, 1'b0, "R4 alternation");

        // R5: full E1 period
        set_src(1'b1, 1'b0, 1'b1, 1'b0);
        hist = '0;
        ones = 0;
        for (int n = 0; n < 32767 + 15; n++) begin
            recv(1'b0, b, "R10 prbs rails");
            if (n >= 15) chk(b == (hist[14] ^ hist[13]), "R5 E1 recurrence", int'(b), int'(hist[14] ^ hist[13]));
            if (n < 15) first[n] = b;
            if (n < 32767 && b) ones++;
            if (n >= 32767) chk(b == first[n - 32767], "R5 E1 period", int'(b), int'(first[n - 32767]));
            hist = {hist[18:0], b};
        end
        chk(ones == 16384, "R5 E1 ones per period", ones, 16384);

        // R6: T1 recurrence
        e1_mode = 1'b0;
        settle();
        hist = '0;
        ones = 0;
        for (int n = 0; n < 300; n++) begin
            recv(1'b0, b, "R10 prbs rails");
            if (n >= 20) chk(b == (hist[19] ^ hist[16]), "R6 T1 recurrence", int'(b), int'(hist[19] ^ hist[16]));
            if (b) ones++;
            hist = {hist[18:0], b};
        end
        chk(ones > 0, "R6 T1 not all zero", ones, 1);
        e1_mode = 1'b1;

        // R7: loop code lengths and restart on entry
        loop_code = 8'hB6;
        for (int s = 0; s < 4; s++) begin
            int len;
            loop_len = 2'(s);
            len = (s >= 2) ? 7 : 5 + s;
            for (int rep = 0; rep < 2; rep++) begin
                set_src(1'b1, 1'b0, 1'b0, 1'b0);
                set_src(1'b1, 1'b0, 1'b0, 1'b1);
                for (int i = 0; i < 2 * len + rep; i++)
                    send(1'b0, loop_code[7 - (i % len)], 1'b0, "R7 loop code bit");
            end
        end

        // R8: one-shot bit error
        set_src(1'b1, 1'b0, 1'b0, 1'b0);
        ctl_ins_err = 1'b1;
        settle();
        send(1'b0, 1'b1, 1'b0, "R8 first bit inverted");
        for (int i = 0; i < 4; i++) send(1'b0, 1'b0, 1'b0, "R8 level held inserts nothing");
        send(1'b1, 1'b1, 1'b0, "R8 level held inserts nothing");
        ctl_ins_err = 1'b0;
        settle();
        send(1'b0, 1'b0, 1'b0, "R8 no error after fall");
        ctl_ins_err = 1'b1;
        send(1'b1, 1'b1, 1'b0, "R8 edge bit unchanged");
        send(1'b1, 1'b0, 1'b0, "R8 re-raised edge inverts one");
        send(1'b1, 1'b1, 1'b0, "R8 only one inverted");
        ctl_ins_err = 1'b0;

        // R9: violation waits for the third consecutive one
        for (int i = 0; i < 2; i++) send(1'b0, 1'b0, 1'b0, "R9 clear run");
        ctl_ins_bpv = 1'b1;
        settle();
        send(1'b1, 1'b1, 1'b0, "R9 run one");
        send(1'b0, 1'b0, 1'b0, "R9 run broken");
        send(1'b1, 1'b1, 1'b0, "R9 first of run");
        send(1'b1, 1'b1, 1'b0, "R9 second of run");
        send(1'b1, 1'b1, 1'b1, "R9 violation on third one");
        send(1'b1, 1'b1, 1'b0, "R10 alternation after violation");
        for (int i = 0; i < 4; i++) send(1'b1, 1'b1, 1'b0, "R9 held level arms nothing");
        ctl_ins_bpv = 1'b0;
        settle();
        ctl_ins_bpv = 1'b1;
        settle();
        send(1'b1, 1'b1, 1'b1, "R9 armed after run already present");
        send(1'b0, 1'b0, 1'b0, "R10 zero both low");
        send(1'b1, 1'b1, 1'b0, "R9 single violation only");
        ctl_ins_bpv = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule